// File: doc/BRIEF.md
# Dual-Bank Graphics Memory Access Port

This block lets a 32-bit host move data in and out of two banks of local graphics memory. Bank 0 stores two 32-bit words per cell, which is 64 bits. Bank 1 stores three words per cell, which is 96 bits: two 32-bit pixels and one word that packs two 16-bit depth values. The host never touches the memory arrays directly. It reaches every cell through a set of per-bank transfer latches. Each bank also has an access-control register, an address register, a mode register and a per-word write mask.

The host either stages words in the latches and commits them to a cell, or pulls a cell into the latches and reads the words back. The access-control register decides what a write to the address register does: load an address, start a read at the stored address, or load an address and read at once. The mode register enables auto-increment and enables commits from latch writes. Together these settings support single explicit accesses and streaming bursts.

The memory read ports are asynchronous. A cell is captured into the latches at the same clock edge as the host write that asks for it.

Top module: `dual_bank_xfer_port`

## Requirements
- R1: After reset, in each bank, access control, address and mode read as 0. The write mask reads as all ones: 3 for bank 0 and 7 for bank 1.
- R2: Host register address bit 3 selects the bank. Bits 2..0 select the register: 0 access control, 1 address, 2 mode, 3 write mask, 4.. transfer latch 0, 1, 2. The address register holds the row in bits 16 and up and the column in bits 9..0. When access control is 0, a write to the address register loads it.
- R3: When mode bit 1 (commit) is set, a commit writes all latched words to the cell at the current address. Latch 0 goes to cell bits 31..0 and each next latch to the next 32 bits. The word being written in that cycle is included.
- R4: When mode bit 0 (increment) is set, the address advances after the commit or read. The column increments; after the last column it returns to 0 and the row increments; the row wraps to 0 after the last row.
- R5: With commit set and increment clear, a write to latch 0 commits the cell and leaves the address unchanged. Writes to the higher latches only stage data.
- R6: When access control is 1 (manual latch), a write to the address register discards the written value and keeps the stored address. It loads the cell at the stored address into the latches.
- R7: When access control is 2 (immediate), a write to the address register loads the new address. In the same cycle it loads the cell at that new address into the latches.
- R8: With both commit and increment set, a write to the highest latch (1 in bank 0, 2 in bank 1) commits the cell and then advances the address. With increment set and commit clear, a host read of the highest latch advances the address.
- R9: A commit writes only the cell words whose write-mask bit is set: bit k covers latch word k. Masked-off words keep their old contents.
- R10: With commit clear, latch writes never write memory.
- R11: Read data appears on the cycle after the read strobe. It holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe |
| hostAddr | input | 4 | Bank select (bit 3) and register index |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Registered host read data |
| m0RdEn | output | 1 | Bank 0 cell read strobe |
| m0WrEn | output | 1 | Bank 0 cell write strobe |
| m0Row | output | 11 | Bank 0 row |
| m0Col | output | 10 | Bank 0 column |
| m0WrData | output | 64 | Bank 0 cell write data |
| m0WrMask | output | 2 | Bank 0 per-word write enables |
| m0RdData | input | 64 | Bank 0 asynchronous cell read data |
| m1RdEn | output | 1 | Bank 1 cell read strobe |
| m1WrEn | output | 1 | Bank 1 cell write strobe |
| m1Row | output | 10 | Bank 1 row |
| m1Col | output | 9 | Bank 1 column |
| m1WrData | output | 96 | Bank 1 cell write data |
| m1WrMask | output | 3 | Bank 1 per-word write enables |
| m1RdData | input | 96 | Bank 1 asynchronous cell read data |

## Verification
In an auto-increment burst, the cell commit and the address advance happen in the same cycle, on the write of the highest latch. The commit must use the address from before the advance. The bench writes bursts of two cells in a row. It then checks the bench memory for each cell at its own location and reads back the address register after the burst. The same collision is driven at the last column and at the last row and column, so that the wrap also falls on the commit cycle.

// File: rtl/dual_bank_xfer_pkg.sv
package dual_bank_xfer_pkg;

  localparam int MAX_WORDS  = 3;
  localparam int REG_CTRL   = 0;
  localparam int REG_ADDR   = 1;
  localparam int REG_MODE   = 2;
  localparam int REG_MASK   = 3;
  localparam int REG_LATCH0 = 4;
  localparam int ROW_LSB    = 16;

  typedef enum logic [1:0] {
    ACC_PLAIN  = 2'd0,
    ACC_MANUAL = 2'd1,
    ACC_IMMED  = 2'd2
  } accCtrl_t;

  typedef struct packed {
    logic                 ldCtrl;
    logic                 ldMode;
    logic                 ldMask;
    logic                 ldAddr;
    logic                 useNewAddr;
    logic                 memRd;
    logic                 memWr;
    logic                 incAddr;
    logic [MAX_WORDS-1:0] ldLatch;
  } strobes_t;

endpackage

// File: rtl/bank_xfer_ctrl.sv
module bank_xfer_ctrl
  import dual_bank_xfer_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bankWr,
  input  logic       bankRd,
  input  logic [2:0] hostReg,
  input  accCtrl_t   accCtrl,
  input  logic       modeInc,
  input  logic       modeCommit,
  output strobes_t   st
);

  localparam logic [2:0] LAST_LATCH = 3'(REG_LATCH0 + NWORDS - 1);

  int trigIdx;

  always_comb begin
    st      = '0;
    trigIdx = modeInc ? NWORDS - 1 : 0;
    if (bankWr) begin
      if (hostReg == 3'(REG_CTRL)) st.ldCtrl = 1'b1;
      if (hostReg == 3'(REG_MODE)) st.ldMode = 1'b1;
      if (hostReg == 3'(REG_MASK)) st.ldMask = 1'b1;
      if (hostReg == 3'(REG_ADDR)) begin
        unique case (accCtrl)
          ACC_MANUAL: st.memRd = 1'b1;
          ACC_IMMED: begin
            st.memRd      = 1'b1;
            st.ldAddr     = 1'b1;
            st.useNewAddr = 1'b1;
          end
          default: st.ldAddr = 1'b1;
        endcase
      end
      for (int k = 0; k < NWORDS; k++) begin
        if (hostReg == 3'(REG_LATCH0 + k)) begin
          st.ldLatch[k] = 1'b1;
          if (modeCommit && (k == trigIdx)) begin
            st.memWr   = 1'b1;
            st.incAddr = modeInc;
          end
        end
      end
    end
    // R8: streaming read advances on the read of the highest latch
    if (bankRd && modeInc && !modeCommit && (hostReg == LAST_LATCH) && !st.ldAddr)
      st.incAddr = 1'b1;
  end

  // R10: a cell write only ever happens with commits enabled
  p_commit_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.memWr |-> modeCommit);

endmodule

// File: rtl/bank_xfer_data.sv
module bank_xfer_data
  import dual_bank_xfer_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic [31:0]           wrData,
  input  logic [2:0]            regSel,
  input  logic [NWORDS*32-1:0]  memRdData,
  output accCtrl_t              accCtrl,
  output logic                  modeInc,
  output logic                  modeCommit,
  output logic [ROW_W-1:0]      memRow,
  output logic [COL_W-1:0]      memCol,
  output logic [NWORDS*32-1:0]  memWrData,
  output logic [NWORDS-1:0]     memWrMask,
  output logic [31:0]           rdWord
);

  logic [ROW_W-1:0]  rowQ, newRow;
  logic [COL_W-1:0]  colQ, newCol;
  logic [NWORDS-1:0] maskQ;
  logic [31:0]       latchQ [NWORDS];
  logic [31:0]       addrView;
  logic              unusedBits;

  assign newRow = wrData[ROW_LSB +: ROW_W];
  assign newCol = wrData[COL_W-1:0];
  assign memRow = st.useNewAddr ? newRow : rowQ;
  assign memCol = st.useNewAddr ? newCol : colQ;
  assign memWrMask = maskQ;
  assign unusedBits = ^{wrData, st.ldLatch};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCtrl    <= ACC_PLAIN;
      modeInc    <= 1'b0;
      modeCommit <= 1'b0;
      maskQ      <= '1;
    end else begin
      if (st.ldCtrl) accCtrl <= accCtrl_t'(wrData[1:0]);
      if (st.ldMode) {modeCommit, modeInc} <= wrData[1:0];
      if (st.ldMask) maskQ <= wrData[NWORDS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (st.ldAddr) begin
      rowQ <= newRow;
      colQ <= newCol;
    end else if (st.incAddr) begin
      if (colQ == '1) begin
        colQ <= '0;
        rowQ <= rowQ + 1'b1;
      end else begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN)               latchQ[k] <= '0;
      else if (st.memRd)       latchQ[k] <= memRdData[k*32 +: 32];
      else if (st.ldLatch[k])  latchQ[k] <= wrData;
    end
    assign memWrData[k*32 +: 32] = st.ldLatch[k] ? wrData : latchQ[k];
  end

  always_comb begin
    addrView = '0;
    addrView[ROW_LSB +: ROW_W] = rowQ;
    addrView[COL_W-1:0]        = colQ;
  end

  always_comb begin
    rdWord = '0;
    if (regSel == 3'(REG_CTRL))      rdWord = {30'd0, accCtrl};
    else if (regSel == 3'(REG_ADDR)) rdWord = addrView;
    else if (regSel == 3'(REG_MODE)) rdWord = {30'd0, modeCommit, modeInc};
    else if (regSel == 3'(REG_MASK)) rdWord = 32'(maskQ);
    else begin
      for (int k = 0; k < NWORDS; k++)
        if (regSel == 3'(REG_LATCH0 + k)) rdWord = latchQ[k];
    end
  end

  // R6: a manual-latch read keeps the stored address
  p_manual_keeps_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.memRd && !st.ldAddr && !st.incAddr) |=> ($stable(rowQ) && $stable(colQ)));

  // R7: an immediate read lands the new address
  p_immed_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.useNewAddr |=> (rowQ == $past(newRow) && colQ == $past(newCol)));

  // R4: column wrap moves to the next row
  p_col_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.incAddr && !st.ldAddr && colQ == '1) |=>
      (colQ == '0 && rowQ == ROW_W'($past(rowQ) + 1'b1)));

endmodule

// File: rtl/dual_bank_xfer_port.sv
module dual_bank_xfer_port
  import dual_bank_xfer_pkg::*;
#(
  parameter int B0_ROW_W = 11,
  parameter int B0_COL_W = 10,
  parameter int B1_ROW_W = 10,
  parameter int B1_COL_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [3:0]          hostAddr,
  input  logic [31:0]         hostWrData,
  output logic [31:0]         hostRdData,
  output logic                m0RdEn,
  output logic                m0WrEn,
  output logic [B0_ROW_W-1:0] m0Row,
  output logic [B0_COL_W-1:0] m0Col,
  output logic [63:0]         m0WrData,
  output logic [1:0]          m0WrMask,
  input  logic [63:0]         m0RdData,
  output logic                m1RdEn,
  output logic                m1WrEn,
  output logic [B1_ROW_W-1:0] m1Row,
  output logic [B1_COL_W-1:0] m1Col,
  output logic [95:0]         m1WrData,
  output logic [2:0]          m1WrMask,
  input  logic [95:0]         m1RdData
);

  strobes_t    st0, st1;
  accCtrl_t    acc0, acc1;
  logic        inc0, inc1, cmt0, cmt1;
  logic [31:0] rd0, rd1;
  logic        sel1;

  assign sel1 = hostAddr[3];

  bank_xfer_ctrl #(.NWORDS(2)) u_ctrl0 (
    .clk(clk), .rstN(rstN),
    .bankWr(hostWrEn && !sel1), .bankRd(hostRdEn && !sel1),
    .hostReg(hostAddr[2:0]), .accCtrl(acc0),
    .modeInc(inc0), .modeCommit(cmt0), .st(st0));

  bank_xfer_data #(.NWORDS(2), .ROW_W(B0_ROW_W), .COL_W(B0_COL_W)) u_data0 (
    .clk(clk), .rstN(rstN), .st(st0), .wrData(hostWrData),
    .regSel(hostAddr[2:0]), .memRdData(m0RdData),
    .accCtrl(acc0), .modeInc(inc0), .modeCommit(cmt0),
    .memRow(m0Row), .memCol(m0Col), .memWrData(m0WrData),
    .memWrMask(m0WrMask), .rdWord(rd0));

  bank_xfer_ctrl #(.NWORDS(3)) u_ctrl1 (
    .clk(clk), .rstN(rstN),
    .bankWr(hostWrEn && sel1), .bankRd(hostRdEn && sel1),
    .hostReg(hostAddr[2:0]), .accCtrl(acc1),
    .modeInc(inc1), .modeCommit(cmt1), .st(st1));

  bank_xfer_data #(.NWORDS(3), .ROW_W(B1_ROW_W), .COL_W(B1_COL_W)) u_data1 (
    .clk(clk), .rstN(rstN), .st(st1), .wrData(hostWrData),
    .regSel(hostAddr[2:0]), .memRdData(m1RdData),
    .accCtrl(acc1), .modeInc(inc1), .modeCommit(cmt1),
    .memRow(m1Row), .memCol(m1Col), .memWrData(m1WrData),
    .memWrMask(m1WrMask), .rdWord(rd1));

  assign m0RdEn = st0.memRd;
  assign m0WrEn = st0.memWr;
  assign m1RdEn = st1.memRd;
  assign m1WrEn = st1.memWr;

  always_ff @(posedge clk) begin
    if (!rstN)         hostRdData <= '0;
    else if (hostRdEn) hostRdData <= sel1 ? rd1 : rd0;
  end

  // R11: read data only changes on the cycle after a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> $stable(hostRdData));

endmodule

// File: tb/dual_bank_xfer_port_tb_top.sv
`timescale 1ns/1ps
module dual_bank_xfer_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        m0RdEn, m0WrEn, m1RdEn, m1WrEn;
  logic [10:0] m0Row;
  logic [9:0]  m0Col;
  logic [9:0]  m1Row;
  logic [8:0]  m1Col;
  logic [63:0] m0WrData, m0RdData;
  logic [95:0] m1WrData, m1RdData;
  logic [1:0]  m0WrMask;
  logic [2:0]  m1WrMask;

  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  dual_bank_xfer_port dut_i (.*);

  // Small behavioural memories indexed by low row/column bits
  logic [63:0] ram0 [64];
  logic [95:0] ram1 [64];
  initial for (int i = 0; i < 64; i++) begin ram0[i] = '0; ram1[i] = '0; end
  assign m0RdData = ram0[{m0Row[2:0], m0Col[2:0]}];
  assign m1RdData = ram1[{m1Row[2:0], m1Col[2:0]}];
  always @(posedge clk) begin
    if (m0WrEn) for (int k = 0; k < 2; k++)
      if (m0WrMask[k]) ram0[{m0Row[2:0], m0Col[2:0]}][k*32 +: 32] <= m0WrData[k*32 +: 32];
    if (m1WrEn) for (int k = 0; k < 3; k++)
      if (m1WrMask[k]) ram1[{m1Row[2:0], m1Col[2:0]}][k*32 +: 32] <= m1WrData[k*32 +: 32];
  end

  typedef struct packed {
    logic        isRd;
    logic [3:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h2, 32'h3,        8'd8},  // R8 bank0 inc+commit
    '{1'b0, 4'h0, 32'h0,        8'd2},  // R2 plain access
    '{1'b0, 4'h1, 32'h00020005, 8'd2},
    '{1'b0, 4'h4, 32'h11111111, 8'd3},
    '{1'b0, 4'h5, 32'h22222222, 8'd3},  // R3 commit (2,5)
    '{1'b0, 4'h4, 32'h33333333, 8'd3},
    '{1'b0, 4'h5, 32'h44444444, 8'd3},  // commit (2,6)
    '{1'b1, 4'h1, 32'h00020007, 8'd8},  // R8 advanced twice
    '{1'b0, 4'h0, 32'h0,        8'd2},
    '{1'b0, 4'h1, 32'h00020005, 8'd2},
    '{1'b0, 4'h2, 32'h1,        8'd8},  // inc, no commit
    '{1'b0, 4'h0, 32'h1,        8'd6},  // R6 manual latch
    '{1'b0, 4'h1, 32'hDEADBEEF, 8'd6},
    '{1'b1, 4'h4, 32'h11111111, 8'd6},
    '{1'b1, 4'h5, 32'h22222222, 8'd8},  // R8 read advance
    '{1'b0, 4'h1, 32'h0,        8'd6},
    '{1'b1, 4'h4, 32'h33333333, 8'd6},
    '{1'b1, 4'h5, 32'h44444444, 8'd11}, // R11 read latency
    '{1'b1, 4'h1, 32'h00020007, 8'd6},  // dummy writes ignored
    '{1'b0, 4'hA, 32'h2,        8'd5},  // R5 bank1 explicit commit
    '{1'b0, 4'h9, 32'h00030004, 8'd5},
    '{1'b0, 4'hB, 32'h7,        8'd9},
    '{1'b0, 4'hE, 32'hAAAA5555, 8'd5},
    '{1'b0, 4'hD, 32'h66666666, 8'd5},
    '{1'b0, 4'hC, 32'h77777777, 8'd5},  // commit (3,4)
    '{1'b0, 4'h8, 32'h2,        8'd7},  // R7 immediate
    '{1'b0, 4'hA, 32'h0,        8'd10},
    '{1'b0, 4'hC, 32'h0,        8'd10},
    '{1'b0, 4'hD, 32'h0,        8'd10},
    '{1'b0, 4'hE, 32'h0,        8'd10},
    '{1'b0, 4'h9, 32'h00030004, 8'd7},
    '{1'b1, 4'hC, 32'h77777777, 8'd7},
    '{1'b1, 4'hD, 32'h66666666, 8'd7},
    '{1'b1, 4'hE, 32'hAAAA5555, 8'd7},
    '{1'b1, 4'h9, 32'h00030004, 8'd7}
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkRd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, 96'(v), 96'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRd("R1 b0 ctrl", 4'h0, 32'h0);
    chkRd("R1 b0 addr", 4'h1, 32'h0);
    chkRd("R1 b0 mode", 4'h2, 32'h0);
    chkRd("R1 b0 mask", 4'h3, 32'h3);
    chkRd("R1 b1 mask", 4'hB, 32'h7);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        rd(VECS[i].a, v);
        nRun++;
        if (v !== VECS[i].d) begin
          nFail++;
          $display("FAIL vec %0d R%0d actual=%h expected=%h", i, VECS[i].req, v, VECS[i].d);
        end
      end else begin
        wr(VECS[i].a, VECS[i].d);
      end
    end

    // R3 burst cells landed at consecutive addresses, word 0 low
    chk("R3 cell(2,5)", 96'(ram0[{3'd2, 3'd5}]), 96'h22222222_11111111);
    chk("R3 cell(2,6)", 96'(ram0[{3'd2, 3'd6}]), 96'h44444444_33333333);
    // R5 explicit commit on latch 0
    chk("R5 b1 cell(3,4)", ram1[{3'd3, 3'd4}], 96'hAAAA5555_66666666_77777777);

    // R9 write mask
    wr(4'h8, 32'h0);
    wr(4'h9, 32'h00010001);
    wr(4'hB, 32'h1);
    wr(4'hA, 32'h2);
    wr(4'hE, 32'h0000BBBB);
    wr(4'hD, 32'h0000CCCC);
    wr(4'hC, 32'h0000DDDD);
    chk("R9 mask pixel0", ram1[{3'd1, 3'd1}], 96'h00000000_00000000_0000DDDD);
    wr(4'hB, 32'h2);
    wr(4'hC, 32'h0000EEEE);
    chk("R9 mask pixel1", ram1[{3'd1, 3'd1}], 96'h00000000_0000CCCC_0000DDDD);
    chkRd("R5 addr kept", 4'h9, 32'h00010001);

    // R10 no commit when commit disabled
    wr(4'h0, 32'h0);
    wr(4'h1, 32'h00060000);
    wr(4'h2, 32'h1);
    wr(4'h4, 32'h5);
    wr(4'h5, 32'h6);
    chk("R10 no write", 96'(ram0[{3'd6, 3'd0}]), 96'h0);
    chkRd("R10 addr unchanged", 4'h1, 32'h00060000);

    // R4 column wrap with commit in same cycle
    wr(4'h2, 32'h3);
    wr(4'h1, 32'h000403FF);
    wr(4'h4, 32'h1);
    wr(4'h5, 32'h2);
    chkRd("R4 col wrap", 4'h1, 32'h00050000);
    chk("R4 wrap cell", 96'(ram0[{3'd4, 3'd7}]), 96'h00000002_00000001);
    wr(4'h1, 32'h07FF03FF);
    wr(4'h4, 32'h9);
    wr(4'h5, 32'hA);
    chkRd("R4 row wrap", 4'h1, 32'h00000000);
    wr(4'hB, 32'h7);
    wr(4'hA, 32'h3);
    wr(4'h9, 32'h000201FF);
    wr(4'hC, 32'h1);
    wr(4'hD, 32'h2);
    wr(4'hE, 32'h3);
    chkRd("R4 b1 col wrap", 4'h9, 32'h00030000);

    // R11 read data holds with no strobe
    rd(4'hA, v);
    repeat (3) @(negedge clk);
    chk("R11 hold", 96'(hostRdData), 96'h3);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule